// File: doc/BRIEF.md
# Per-Lane Two-Entry Load Result Buffer

This block sits between the read-data beats returned by memory and the write ports of a lane-split vector register file. Each accepted beat is cut down to the bytes that belong to the current load instruction, using a lower and an upper byte bound. The surviving bytes are permuted into lane order according to the element width. Each lane that receives any of them gets one new entry. An entry holds the lane's write data, the byte enables, the register file address and the instruction ID.

Every lane owns exactly two entries, used in first-in first-out order. The lane raises a write request while it holds an entry and keeps every field steady until the lane answers with its final grant, which frees the entry. A beat is taken only when every lane it touches can store one more entry.

Each lane is tracked by a small state machine with three states. L_EMPTY means no entry is held. L_ONE means one entry is held. L_TWO means both entries are held. The transitions are as follows:
- push: L_EMPTY→L_ONE and L_ONE→L_TWO.
- release: L_ONE→L_EMPTY and L_TWO→L_ONE.
- push and release in the same cycle: L_ONE stays in L_ONE.
- Any other case: the state holds.

Top module: `lane_result_buffer`

## Requirements
- R1: A destination byte j of lane l receives the beat byte with index ((j>>s)·NUM_LANES + l)·2^s + (j mod 2^s). Here s is the element shift taken from beat_sew: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and 3 is clamped to the lane width (2 with the defaults).
- R2: A beat byte takes part only if beat_lo ≤ index < beat_hi. A lane is touched, and gets an entry, only if at least one participating byte maps to it. Enables of non-participating bytes are 0. A beat with beat_lo ≥ beat_hi touches no lane and is always accepted.
- R3: Participating beat bytes with index below beat_skip still touch their lane, but their byte enables are 0. This gives a partial first write.
- R4: When beat_vm is 0, destination byte j of lane l is enabled only if beat_mask[l·LANE_BYTES + j] is 1. When beat_vm is 1, the mask is ignored.
- R5: Each new entry stores the address {beat_vreg, beat_row}, which equals beat_vreg·2^ROW_W + beat_row, and stores beat_id.
- R6: beat_ready is 1 exactly when every touched lane holds fewer than two entries.
- R7: lane_req[l] is 1 while lane l holds an entry. The oldest entry is shown, and its fields stay stable until lane_gnt[l] is 1 at a clock edge, which frees it. Entries leave in arrival order.
- R8: A lane_gnt with lane_req low has no effect.
- R9: After reset no lane requests and beat_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| beat_valid | input | 1 | Beat offered |
| beat_ready | output | 1 | Beat taken this cycle if valid |
| beat_data | input | NUM_LANES·LANE_BYTES·8 | Beat bytes |
| beat_lo | input | clog2(NUM_LANES·LANE_BYTES)+1 | First participating byte |
| beat_hi | input | clog2(NUM_LANES·LANE_BYTES)+1 | One past last participating byte |
| beat_skip | input | clog2(NUM_LANES·LANE_BYTES)+1 | Bytes below this index are written disabled |
| beat_sew | input | 2 | Element width code |
| beat_vm | input | 1 | 1 = unmasked |
| beat_mask | input | NUM_LANES·LANE_BYTES | Per-lane byte mask |
| beat_vreg | input | VREG_W | Destination register number |
| beat_row | input | ROW_W | Row within the register |
| beat_id | input | ID_W | Instruction ID |
| lane_req | output | NUM_LANES | Write request per lane |
| lane_gnt | input | NUM_LANES | Final grant per lane |
| lane_wdata | output | NUM_LANES·LANE_BYTES·8 | Write data, lane l at l·LANE_BYTES·8 |
| lane_be | output | NUM_LANES·LANE_BYTES | Byte enables |
| lane_addr | output | NUM_LANES·(VREG_W+ROW_W) | Register file address |
| lane_id | output | NUM_LANES·ID_W | Instruction ID |

## Verification
A lane state machine that lost count shows up in one of two ways. An entry may be released early, so lane_req drops or the shown fields change before the grant. Or the lane may keep requesting a stale entry. Either appears at the lane ports in the cycle after the faulty edge. A pointer or permutation fault shows as wrong data, enables or address on the next visible entry. A wrong fullness view shows on beat_ready in the same cycle the beat is offered.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    typedef enum logic [1:0] {
        L_EMPTY = 2'd0,
        L_ONE   = 2'd1,
        L_TWO   = 2'd2
    } occ_e;

    function automatic int elem_shift(input logic [1:0] sew, input int max_shift);
        int s;
        s = int'(sew);
        return (s > max_shift) ? max_shift : s;
    endfunction

endpackage

// File: rtl/lrb_slice.sv
module lrb_slice #(
    parameter int NUM_LANES  = 4,
    parameter int LANE_BYTES = 4,
    parameter int BOUND_W    = 5
) (
    input  logic [NUM_LANES*LANE_BYTES*8-1:0] beat_data,
    input  logic [BOUND_W-1:0]                beat_lo,
    input  logic [BOUND_W-1:0]                beat_hi,
    input  logic [BOUND_W-1:0]                beat_skip,
    input  logic [1:0]                        beat_sew,
    input  logic                              beat_vm,
    input  logic [NUM_LANES*LANE_BYTES-1:0]   beat_mask,
    output logic [NUM_LANES*LANE_BYTES*8-1:0] sl_data,
    output logic [NUM_LANES*LANE_BYTES-1:0]   sl_be,
    output logic [NUM_LANES-1:0]              sl_touch
);
    localparam int LB_SHIFT = $clog2(LANE_BYTES);

    always_comb begin
        int sw;
        int slot;
        int part;
        int src;
        logic [BOUND_W-1:0] src_b;
        logic in_win;
        sl_data  = '0;
        sl_be    = '0;
        sl_touch = '0;
        sw = lrb_pkg::elem_shift(beat_sew, LB_SHIFT);
        for (int l = 0; l < NUM_LANES; l++) begin
            for (int j = 0; j < LANE_BYTES; j++) begin
                slot  = j >> sw;
                part  = j & ((1 << sw) - 1);
                src   = ((slot * NUM_LANES + l) << sw) + part;
                src_b = BOUND_W'(src);
                in_win = (src_b >= beat_lo) && (src_b < beat_hi);
                sl_data[(l*LANE_BYTES+j)*8 +: 8] = beat_data[src*8 +: 8];
                sl_be[l*LANE_BYTES+j] = in_win && (src_b >= beat_skip)
                                        && (beat_vm || beat_mask[l*LANE_BYTES+j]);
                if (in_win) begin
                    sl_touch[l] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lrb_lane.sv
module lrb_lane #(
    parameter int DW  = 32,
    parameter int BEW = 4,
    parameter int AW  = 8,
    parameter int IW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [DW-1:0]  in_data,
    input  logic [BEW-1:0] in_be,
    input  logic [AW-1:0]  in_addr,
    input  logic [IW-1:0]  in_id,
    input  logic           gnt,
    output logic           free,
    output logic           req,
    output logic [DW-1:0]  out_data,
    output logic [BEW-1:0] out_be,
    output logic [AW-1:0]  out_addr,
    output logic [IW-1:0]  out_id
);
    import lrb_pkg::*;

    occ_e state_q, state_d;
    logic wr_q, rd_q;
    logic pop;

    logic [DW-1:0]  data_q [2];
    logic [BEW-1:0] be_q   [2];
    logic [AW-1:0]  addr_q [2];
    logic [IW-1:0]  id_q   [2];

    assign pop = gnt && req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= L_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_EMPTY: if (push) state_d = L_ONE;
            L_ONE: begin
                if (push && !pop) state_d = L_TWO;
                else if (pop && !push) state_d = L_EMPTY;
            end
            L_TWO: if (pop) state_d = L_ONE;
            default: state_d = L_EMPTY;
        endcase
    end

    always_comb begin
        req      = (state_q != L_EMPTY);
        free     = (state_q != L_TWO);
        out_data = data_q[rd_q];
        out_be   = be_q[rd_q];
        out_addr = addr_q[rd_q];
        out_id   = id_q[rd_q];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            if (push) wr_q <= ~wr_q;
            if (pop)  rd_q <= ~rd_q;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            data_q[wr_q] <= in_data;
            be_q[wr_q]   <= in_be;
            addr_q[wr_q] <= in_addr;
            id_q[wr_q]   <= in_id;
        end
    end

endmodule

// File: rtl/lane_result_buffer.sv
module lane_result_buffer #(
    parameter int NUM_LANES  = 4,
    parameter int LANE_BYTES = 4,
    parameter int VREG_W     = 5,
    parameter int ROW_W      = 3,
    parameter int ID_W       = 3,
    localparam int BEAT_BYTES = NUM_LANES * LANE_BYTES,
    localparam int BOUND_W    = $clog2(BEAT_BYTES) + 1,
    localparam int ADDR_W     = VREG_W + ROW_W,
    localparam int LANE_DW    = LANE_BYTES * 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          beat_valid,
    output logic                          beat_ready,
    input  logic [BEAT_BYTES*8-1:0]       beat_data,
    input  logic [BOUND_W-1:0]            beat_lo,
    input  logic [BOUND_W-1:0]            beat_hi,
    input  logic [BOUND_W-1:0]            beat_skip,
    input  logic [1:0]                    beat_sew,
    input  logic                          beat_vm,
    input  logic [BEAT_BYTES-1:0]         beat_mask,
    input  logic [VREG_W-1:0]             beat_vreg,
    input  logic [ROW_W-1:0]              beat_row,
    input  logic [ID_W-1:0]               beat_id,
    output logic [NUM_LANES-1:0]          lane_req,
    input  logic [NUM_LANES-1:0]          lane_gnt,
    output logic [NUM_LANES*LANE_DW-1:0]  lane_wdata,
    output logic [BEAT_BYTES-1:0]         lane_be,
    output logic [NUM_LANES*ADDR_W-1:0]   lane_addr,
    output logic [NUM_LANES*ID_W-1:0]     lane_id
);
    logic [BEAT_BYTES*8-1:0] sl_data;
    logic [BEAT_BYTES-1:0]   sl_be;
    logic [NUM_LANES-1:0]    sl_touch;
    logic [NUM_LANES-1:0]    lane_free;
    logic [ADDR_W-1:0]       entry_addr;
    logic                    take;

    lrb_slice #(
        .NUM_LANES (NUM_LANES),
        .LANE_BYTES(LANE_BYTES),
        .BOUND_W   (BOUND_W)
    ) u_slice (
        .beat_data(beat_data),
        .beat_lo  (beat_lo),
        .beat_hi  (beat_hi),
        .beat_skip(beat_skip),
        .beat_sew (beat_sew),
        .beat_vm  (beat_vm),
        .beat_mask(beat_mask),
        .sl_data  (sl_data),
        .sl_be    (sl_be),
        .sl_touch (sl_touch)
    );

    assign entry_addr = {beat_vreg, beat_row};
    assign beat_ready = &(~sl_touch | lane_free);
    assign take       = beat_valid && beat_ready;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        lrb_lane #(
            .DW (LANE_DW),
            .BEW(LANE_BYTES),
            .AW (ADDR_W),
            .IW (ID_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (take && sl_touch[l]),
            .in_data (sl_data[l*LANE_DW +: LANE_DW]),
            .in_be   (sl_be[l*LANE_BYTES +: LANE_BYTES]),
            .in_addr (entry_addr),
            .in_id   (beat_id),
            .gnt     (lane_gnt[l]),
            .free    (lane_free[l]),
            .req     (lane_req[l]),
            .out_data(lane_wdata[l*LANE_DW +: LANE_DW]),
            .out_be  (lane_be[l*LANE_BYTES +: LANE_BYTES]),
            .out_addr(lane_addr[l*ADDR_W +: ADDR_W]),
            .out_id  (lane_id[l*ID_W +: ID_W])
        );
    end

endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
    parameter int NUM_LANES  = 4,
    parameter int LANE_BYTES = 4,
    parameter int BOUND_W    = 5,
    parameter int ADDR_W     = 8,
    parameter int ID_W       = 3
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              beat_valid,
    input logic                              beat_ready,
    input logic [BOUND_W-1:0]                beat_lo,
    input logic [BOUND_W-1:0]                beat_hi,
    input logic [NUM_LANES-1:0]              lane_req,
    input logic [NUM_LANES-1:0]              lane_gnt,
    input logic [NUM_LANES*LANE_BYTES*8-1:0] lane_wdata,
    input logic [NUM_LANES*LANE_BYTES-1:0]   lane_be,
    input logic [NUM_LANES*ADDR_W-1:0]       lane_addr,
    input logic [NUM_LANES*ID_W-1:0]         lane_id
);
    localparam int DW = LANE_BYTES * 8;

    p_empty_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_lo >= beat_hi) |-> beat_ready);

    p_stall_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |-> (|lane_req));

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
        p_hold_until_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_req[l] && !lane_gnt[l]) |=>
                (lane_req[l] && $stable(lane_wdata[l*DW +: DW])
                 && $stable(lane_be[l*LANE_BYTES +: LANE_BYTES])
                 && $stable(lane_addr[l*ADDR_W +: ADDR_W])
                 && $stable(lane_id[l*ID_W +: ID_W])));

        p_idle_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!lane_req[l] && lane_gnt[l] && !(beat_valid && beat_ready)) |=> !lane_req[l]);
    end

endmodule

bind lane_result_buffer lrb_checker #(
    .NUM_LANES (NUM_LANES),
    .LANE_BYTES(LANE_BYTES),
    .BOUND_W   (BOUND_W),
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_valid(beat_valid),
    .beat_ready(beat_ready),
    .beat_lo   (beat_lo),
    .beat_hi   (beat_hi),
    .lane_req  (lane_req),
    .lane_gnt  (lane_gnt),
    .lane_wdata(lane_wdata),
    .lane_be   (lane_be),
    .lane_addr (lane_addr),
    .lane_id   (lane_id)
);

// File: tb/sim_lane_result_buffer.sv
`timescale 1ns/1ps
module sim_lane_result_buffer;
    localparam int NL = 4;
    localparam int LB = 4;
    localparam int BB = NL * LB;

    typedef struct packed {
        logic [31:0] d;
        logic [3:0]  be;
        logic [7:0]  a;
        logic [2:0]  id;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          beat_valid = 1'b0;
    logic          beat_ready;
    logic [127:0]  beat_data = '0;
    logic [4:0]    beat_lo = '0, beat_hi = '0, beat_skip = '0;
    logic [1:0]    beat_sew = '0;
    logic          beat_vm = 1'b1;
    logic [15:0]   beat_mask = '0;
    logic [4:0]    beat_vreg = '0;
    logic [2:0]    beat_row = '0;
    logic [2:0]    beat_id = '0;
    logic [NL-1:0] lane_req;
    logic [NL-1:0] lane_gnt = '0;
    logic [127:0]  lane_wdata;
    logic [15:0]   lane_be;
    logic [31:0]   lane_addr;
    logic [11:0]   lane_id;

    lane_result_buffer u0 (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_data(beat_data), .beat_lo(beat_lo), .beat_hi(beat_hi), .beat_skip(beat_skip),
        .beat_sew(beat_sew), .beat_vm(beat_vm), .beat_mask(beat_mask), .beat_vreg(beat_vreg),
        .beat_row(beat_row), .beat_id(beat_id), .lane_req(lane_req), .lane_gnt(lane_gnt),
        .lane_wdata(lane_wdata), .lane_be(lane_be), .lane_addr(lane_addr), .lane_id(lane_id)
    );

    int checks = 0;
    int errors = 0;
    ent_t mq [NL][2];
    int   cnt [NL];
    ent_t xe [NL];
    logic [NL-1:0] xt;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Forward mapping from beat byte to (lane, lane byte) per R1..R5
    task automatic expect_beat();
        int sw, e, k, ln, lb;
        for (int l = 0; l < NL; l++) begin
            xe[l] = '0;
            xe[l].a = {beat_vreg, beat_row};
            xe[l].id = beat_id;
        end
        xt = '0;
        sw = (beat_sew > 2) ? 2 : int'(beat_sew);
        for (int b = 0; b < BB; b++) begin
            e  = b >> sw;
            k  = b & ((1 << sw) - 1);
            ln = e % NL;
            lb = ((e / NL) << sw) + k;
            xe[ln].d[lb*8 +: 8] = beat_data[b*8 +: 8];
            if (b >= int'(beat_lo) && b < int'(beat_hi)) begin
                xt[ln] = 1'b1;
                xe[ln].be[lb] = (b >= int'(beat_skip)) && (beat_vm || beat_mask[ln*LB+lb]);
            end
        end
    endtask

    // One cycle: inputs already set; called after the negedge
    task automatic cycle();
        logic exp_ready;
        #1;
        expect_beat();
        exp_ready = 1'b1;
        for (int l = 0; l < NL; l++) if (xt[l] && cnt[l] >= 2) exp_ready = 1'b0;
        check("R6 R2 beat_ready", 64'(beat_ready), 64'(exp_ready));
        for (int l = 0; l < NL; l++) begin
            check($sformatf("R7 R8 R9 lane%0d req", l), 64'(lane_req[l]), 64'(cnt[l] > 0));
            if (cnt[l] > 0) begin
                check($sformatf("R1 lane%0d data", l), 64'(lane_wdata[l*32 +: 32]), 64'(mq[l][0].d));
                check($sformatf("R2 R3 R4 lane%0d be", l), 64'(lane_be[l*4 +: 4]), 64'(mq[l][0].be));
                check($sformatf("R5 lane%0d addr", l), 64'(lane_addr[l*8 +: 8]), 64'(mq[l][0].a));
                check($sformatf("R5 lane%0d id", l), 64'(lane_id[l*3 +: 3]), 64'(mq[l][0].id));
            end
        end
        for (int l = 0; l < NL; l++) begin
            if (lane_gnt[l] && cnt[l] > 0) begin
                mq[l][0] = mq[l][1];
                cnt[l]--;
            end
        end
        if (beat_valid && exp_ready) begin
            for (int l = 0; l < NL; l++) begin
                if (xt[l]) begin
                    mq[l][cnt[l]] = xe[l];
                    cnt[l]++;
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic set_beat(input logic v, input int lo, input int hi, input int skip,
                            input int sew, input logic vm);
        beat_valid = v;
        beat_data  = {$urandom, $urandom, $urandom, $urandom};
        beat_lo    = 5'(lo);
        beat_hi    = 5'(hi);
        beat_skip  = 5'(skip);
        beat_sew   = 2'(sew);
        beat_vm    = vm;
        beat_mask  = 16'($urandom);
        beat_vreg  = 5'($urandom);
        beat_row   = 3'($urandom);
        beat_id    = 3'($urandom);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int l = 0; l < NL; l++) cnt[l] = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 req at reset", 64'(lane_req), 64'(0));
        check("R9 ready at reset", 64'(beat_ready), 64'(1));
        rst_n = 1'b1;
        @(negedge clk);
        // R6: fill both entries of every lane with no grants
        lane_gnt = '0;
        set_beat(1'b1, 0, 16, 0, 0, 1'b1); cycle();
        set_beat(1'b1, 0, 16, 0, 1, 1'b1); cycle();
        set_beat(1'b1, 0, 16, 0, 2, 1'b1); cycle();
        // R2: empty window accepted while full
        set_beat(1'b1, 7, 7, 0, 0, 1'b1); cycle();
        set_beat(1'b1, 9, 3, 0, 0, 1'b1); cycle();
        // R7: drain lane by lane
        lane_gnt = 4'b0001; set_beat(1'b0, 0, 0, 0, 0, 1'b1); cycle(); cycle();
        lane_gnt = 4'b1111; cycle(); cycle(); cycle();
        // R8: grants with nothing held
        cycle(); cycle();
        lane_gnt = '0;
        // R3 + R4: vstart partial write, masked, 2-byte elements
        set_beat(1'b1, 2, 14, 6, 1, 1'b0); cycle();
        set_beat(1'b1, 5, 11, 8, 3, 1'b0); cycle();
        lane_gnt = 4'b1111; set_beat(1'b0, 0, 0, 0, 0, 1'b1); cycle(); cycle(); cycle();
        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            int lo, hi;
            lo = $urandom_range(0, 16);
            hi = $urandom_range(0, 16);
            lane_gnt = 4'($urandom);
            set_beat(($urandom % 10) < 7, lo, hi, $urandom_range(0, 16),
                     $urandom_range(0, 3), 1'($urandom));
            cycle();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule